// File: doc/BRIEF.md
# Caption Line Bit Serializer

The block produces the digital bit stream that is keyed onto the caption line of a video signal. Each frame carries two fields. For each field, software stores two 7-bit characters and sets an enable bit. The video timing logic pulses a line strobe at the start of the caption line and names the current field. If that field is enabled, the block sends a fixed sequence on a single data-level output: a clock run-in, a start pattern, and then the two characters. Each character goes out least significant bit first and is followed by a parity bit that the block computes.

The symbol rate comes from the 27 MHz pixel clock through a fractional accumulator. A whole line is divided into an integer number of bit slots, so no exact integer clock divisor is needed. A sticky status bit for each field tells software that the characters it loaded have been sent. Writing that field's second character clears the bit. Software can therefore reload once per frame and wait for the status before the next load. The characters are copied at the start of each transmission, so a register write during a line takes effect on the next line only. Analog shaping of the waveform is done elsewhere.

Top module: `cap_line_ser`

## Requirements
- R1: After reset, capData, capActive, both sentStatus bits and both field enables are 0.
- R2: Register writes (wrEn high, sampled on a clock edge) decode wrAddr as follows. Address 0 is field 1 character 1, address 1 is field 1 character 2, address 2 is field 2 character 1, and address 3 is field 2 character 2. For these four addresses, wrData[6:0] is stored and wrData[7] is ignored. At address 4, wrData[0] enables field 1 and wrData[1] enables field 2.
- R3: A lineStart pulse starts a transmission only if the field named by fieldSel (0 = field 1, 1 = field 2) is enabled. Otherwise capData and capActive stay 0 and sentStatus does not change.
- R4: A transmission is 52 half-bit symbols. Each half-bit lasts LINE_CLKS/(2*BITS_PER_LINE) clocks on average (26.8 clocks by default), produced by fractional accumulation. capActive is high throughout the transmission and returns to 0 afterwards.
- R5: The run-in is 7 bit periods. In each one, capData is 1 for the first half and 0 for the second.
- R6: Three start bits follow the run-in, with the values 0, 0, 1.
- R7: Character 1 and then character 2 follow. Each is sent as bits 0 to 6 and then a parity bit that makes the number of ones among the eight bits odd. Each bit holds for two half-bit symbols.
- R8: When a field's transmission ends, that field's sentStatus bit sets. A write to that field's character 2 address clears it. The other field's bit is not affected.
- R9: A lineStart pulse during a transmission is ignored; the current transmission continues unchanged.
- R10: The characters are captured when a transmission starts. A write during a transmission changes only later transmissions.
- R11: capData is 0 whenever capActive is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| lineStart | input | 1 | One-clock pulse at the start of the caption line |
| fieldSel | input | 1 | Current field, 0 = field 1, 1 = field 2 |
| capData | output | 1 | Serial caption data level |
| capActive | output | 1 | High while a transmission is in progress |
| sentStatus | output | 2 | Per-field sent flags, bit 0 = field 1 |

## Verification
The hardest situation to create from the ports is a transmission that is disturbed while it runs. The test must land a character write and a second line strobe in the middle of a line. It must then show that neither the running symbol stream nor its timing moves. The bench injects both events one clock after it samples a symbol in the data section and keeps sampling every later half-bit at its predicted centre. It then sends another line to show that the new character was captured.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int CHAR_W     = 7;
  localparam int START_BITS = 3;
  localparam int IDX_W      = 7;

  typedef struct packed {
    logic             startLine;
    logic             finish;
    logic             busy;
    logic             field;
    logic [IDX_W-1:0] halfIdx;
  } capStrb_t;
endpackage

// File: rtl/cap_ser_ctrl.sv
module cap_ser_ctrl
  import cap_pkg::*;
#(
  parameter int LINE_CLKS     = 1716,
  parameter int BITS_PER_LINE = 32,
  parameter int RUNIN_CYCLES  = 7
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     lineStart,
  input  logic     fieldSel,
  input  logic [1:0] fieldEn,
  output capStrb_t strb
);
  localparam int STEP       = 2 * BITS_PER_LINE;
  localparam int HALF_TOTAL = 2 * (RUNIN_CYCLES + START_BITS + 2 * (CHAR_W + 1));
  localparam int ACC_W      = $clog2(LINE_CLKS + STEP + 1);

  logic [ACC_W-1:0] acc, accNext;
  logic [IDX_W-1:0] halfIdx;
  logic busy, fieldQ, tick, launch, lastHalf;

  always_comb begin
    accNext  = acc + ACC_W'(STEP);
    tick     = busy && (accNext >= ACC_W'(LINE_CLKS));
    launch   = !busy && lineStart && fieldEn[fieldSel];
    lastHalf = tick && (halfIdx == IDX_W'(HALF_TOTAL - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0; halfIdx <= '0; busy <= 1'b0; fieldQ <= 1'b0;
    end else if (launch) begin
      acc <= '0; halfIdx <= '0; busy <= 1'b1; fieldQ <= fieldSel;
    end else if (busy) begin
      if (tick) begin
        acc <= accNext - ACC_W'(LINE_CLKS);
        if (lastHalf) busy <= 1'b0;
        else          halfIdx <= halfIdx + 1'b1;
      end else begin
        acc <= accNext;
      end
    end
  end

  always_comb begin
    strb.startLine = launch;
    strb.finish    = lastHalf;
    strb.busy      = busy;
    strb.field     = launch ? fieldSel : fieldQ;
    strb.halfIdx   = halfIdx;
  end

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && !lastHalf |=> busy);
endmodule

// File: rtl/cap_ser_data.sv
module cap_ser_data
  import cap_pkg::*;
#(
  parameter int RUNIN_CYCLES = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  capStrb_t   strb,
  output logic [1:0] fieldEn,
  output logic [1:0] sentStatus,
  output logic       capData,
  output logic       capActive
);
  localparam int RUNIN_H    = 2 * RUNIN_CYCLES;
  localparam int DATA_OFS   = RUNIN_H + 2 * START_BITS;
  localparam int HALF_TOTAL = DATA_OFS + 4 * (CHAR_W + 1);
  localparam int NUM_WORDS  = 4;

  logic [CHAR_W-1:0] words [NUM_WORDS];
  logic [CHAR_W-1:0] snapW1, snapW2;
  logic [CHAR_W:0]   byte1, byte2;
  logic [IDX_W-1:0]  rel;
  logic              sym;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) words[i] <= '0;
      fieldEn <= '0;
    end else if (wrEn) begin
      if (wrAddr[2]) begin
        if (wrAddr[1:0] == 2'd0) fieldEn <= wrData[1:0];
      end else begin
        words[wrAddr[1:0]] <= wrData[CHAR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapW1 <= '0; snapW2 <= '0;
    end else if (strb.startLine) begin
      snapW1 <= words[{strb.field, 1'b0}];
      snapW2 <= words[{strb.field, 1'b1}];
    end
  end

  always_comb begin
    byte1 = {~^snapW1, snapW1};
    byte2 = {~^snapW2, snapW2};
    rel   = strb.halfIdx - IDX_W'(DATA_OFS);
    sym   = 1'b0;
    if (strb.halfIdx < IDX_W'(RUNIN_H)) begin
      sym = ~strb.halfIdx[0];
    end else if (strb.halfIdx < IDX_W'(DATA_OFS)) begin
      rel = strb.halfIdx - IDX_W'(RUNIN_H);
      sym = (rel[IDX_W-1:1] == (IDX_W-1)'(START_BITS - 1));
    end else begin
      sym = rel[4] ? byte2[rel[3:1]] : byte1[rel[3:1]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capData <= 1'b0; capActive <= 1'b0;
    end else begin
      capData   <= strb.busy & sym;
      capActive <= strb.busy;
    end
  end

  for (genvar f = 0; f < 2; f++) begin : g_status
    logic clrHit;
    assign clrHit = wrEn && (wrAddr == {1'b0, f[0], 1'b1});
    always_ff @(posedge clk) begin
      if (!rstN)                                   sentStatus[f] <= 1'b0;
      else if (clrHit)                             sentStatus[f] <= 1'b0;
      else if (strb.finish && strb.field == f[0])  sentStatus[f] <= 1'b1;
    end
  end

  // R3
  start_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startLine |-> fieldEn[strb.field]);
  // R4
  half_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |-> strb.halfIdx < IDX_W'(HALF_TOTAL));
  // R8
  status1_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sentStatus[0]) |-> $past(strb.finish && !strb.field));
  // R8
  status2_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sentStatus[1]) |-> $past(strb.finish && strb.field));
endmodule

// File: rtl/cap_line_ser.sv
module cap_line_ser
  import cap_pkg::*;
#(
  parameter int LINE_CLKS     = 1716,
  parameter int BITS_PER_LINE = 32,
  parameter int RUNIN_CYCLES  = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       lineStart,
  input  logic       fieldSel,
  output logic       capData,
  output logic       capActive,
  output logic [1:0] sentStatus
);
  capStrb_t   strb;
  logic [1:0] fieldEn;

  cap_ser_ctrl #(
    .LINE_CLKS(LINE_CLKS), .BITS_PER_LINE(BITS_PER_LINE), .RUNIN_CYCLES(RUNIN_CYCLES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .fieldSel(fieldSel),
    .fieldEn(fieldEn), .strb(strb)
  );

  cap_ser_data #(.RUNIN_CYCLES(RUNIN_CYCLES)) i_data (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .fieldEn(fieldEn), .sentStatus(sentStatus),
    .capData(capData), .capActive(capActive)
  );

  // R11
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(capActive) |-> !capData);
endmodule

// File: tb/test_cap_line_ser.sv
module test_cap_line_ser;
  localparam int LINE   = 1716;
  localparam int STEP   = 64;
  localparam int HALVES = 52;
  localparam int NVEC   = 5;
  // {field, char1, char2}
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b0, 7'h00, 7'h7F}, {1'b1, 7'h41, 7'h2A}, {1'b0, 7'h55, 7'h13},
    {1'b1, 7'h7F, 7'h00}, {1'b0, 7'h01, 7'h40}};

  logic clk = 0, rstN = 0, wrEn = 0, lineStart = 0, fieldSel = 0;
  logic [2:0] wrAddr = 0;
  logic [7:0] wrData = 0;
  logic capData, capActive;
  logic [1:0] sentStatus;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cap_line_ser i_cap_line_ser (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lineStart(lineStart), .fieldSel(fieldSel), .capData(capData),
    .capActive(capActive), .sentStatus(sentStatus));

  function automatic logic expSym(int k, logic [6:0] w1, logic [6:0] w2);
    logic [7:0] b;
    int d;
    if (k < 14) return (k % 2 == 0);
    if (k < 20) return ((k - 14) / 2 == 2);
    d = k - 20;
    b = (d < 16) ? {~^w1, w1} : {~^w2, w2};
    return b[(d % 16) / 2];
  endfunction

  function automatic string tagOf(int k);
    if (k < 14) return "R5";
    if (k < 20) return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  // disturb: inject a char-1 write and a lineStart after half 24
  task automatic runFrame(input logic fld, input logic [6:0] w1, input logic [6:0] w2,
                          input bit disturb);
    int cnt;
    int tgt;
    @(negedge clk); lineStart = 1; fieldSel = fld;
    @(posedge clk); cnt = 0;
    @(negedge clk); lineStart = 0;
    for (int k = 0; k < HALVES; k++) begin
      tgt = ((2 * k + 1) * LINE) / (2 * STEP) + 1;
      while (cnt < tgt) begin @(posedge clk); cnt++; end
      #1;
      check(tagOf(k), {7'b0, capData}, {7'b0, expSym(k, w1, w2)});
      check("R4", {7'b0, capActive}, 8'd1);
      if (disturb && k == 24) begin
        wrEn = 1; wrAddr = {1'b0, fld, 1'b0}; wrData = {1'b0, ~w1};
        lineStart = 1; fieldSel = fld;
        @(posedge clk); cnt++; #1;
        wrEn = 0; lineStart = 0;
      end
    end
    while (cnt < (HALVES * LINE) / STEP + 4) begin @(posedge clk); cnt++; end
    #1;
    check("R4", {7'b0, capActive}, 8'd0);
    check("R11", {7'b0, capData}, 8'd0);
    check("R8", {7'b0, sentStatus[fld]}, 8'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", {5'b0, capData, capActive, 1'b0}, 8'd0);
    check("R1", {6'b0, sentStatus}, 8'd0);
    @(negedge clk); rstN = 1;
    // R1/R3: enables reset to 0, so a line strobe does nothing
    @(negedge clk); lineStart = 1; fieldSel = 0;
    @(negedge clk); lineStart = 0;
    repeat (60) @(posedge clk);
    #1 check("R3", {6'b0, capActive, capData}, 8'd0);
    // R3: only field 2 enabled, field 1 strobe ignored
    wrReg(3'd4, 8'h02);
    @(negedge clk); lineStart = 1; fieldSel = 0;
    @(negedge clk); lineStart = 0;
    repeat (60) @(posedge clk);
    #1 check("R3", {6'b0, capActive, capData}, 8'd0);
    check("R3", {6'b0, sentStatus}, 8'd0);
    wrReg(3'd4, 8'h03);
    // table walk: R2 (bit 7 set and ignored), R5, R6, R7, R8
    for (int v = 0; v < NVEC; v++) begin
      logic fld;
      logic [6:0] c1, c2;
      {fld, c1, c2} = VEC[v];
      wrReg({1'b0, fld, 1'b0}, {1'b1, c1});
      wrReg({1'b0, fld, 1'b1}, {1'b1, c2});
      #1 check("R8", {7'b0, sentStatus[fld]}, 8'd0);
      runFrame(fld, c1, c2, 1'b0);
    end
    // R8: clearing one field leaves the other
    wrReg(3'd3, 8'h10);
    #1 check("R8", {6'b0, sentStatus}, 8'b01);
    wrReg(3'd1, 8'h22);
    #1 check("R8", {6'b0, sentStatus}, 8'b00);
    // R9/R10: disturbance mid-line, then next line uses new char 1
    wrReg(3'd0, 8'h35);
    runFrame(1'b0, 7'h35, 7'h22, 1'b1);
    runFrame(1'b0, ~7'h35, 7'h22, 1'b0);
    // R2: address 4 write disables field 2
    wrReg(3'd4, 8'h01);
    @(negedge clk); lineStart = 1; fieldSel = 1;
    @(negedge clk); lineStart = 0;
    repeat (60) @(posedge clk);
    #1 check("R2", {7'b0, capActive}, 8'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule